// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a small word-addressed memory and serves one requester. Besides plain reads and writes it offers a load-linked operation, which returns a word and arms a reservation on the line that holds it, and a store-conditional operation, which writes only while that reservation is still alive and reports whether the write took place. The requester can build any atomic read-modify-write sequence from the pair, retrying whenever the conditional store reports failure.

The reservation is a single flag plus a stored line number. Four kinds of events kill it: an invalidation strobe whose address falls in the reserved line, an eviction strobe whose address falls in the reserved line, a context-switch pulse, and an interrupt pulse when the interrupt-kill configuration input is high. Every request is accepted on the cycle it is presented and answered exactly one cycle later.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked request (op code 2) returns the stored word at its address and arms the reservation on that address's line, where the line number is the address divided by LINE_WORDS (default 4).
- R2: A store-conditional request (op code 3) whose address lies in the reserved line while the reservation is armed writes its data and responds with rsp_sc_ok = 1.
- R3: After reset the reservation is disarmed and every memory word reads as zero; a store-conditional with no armed reservation responds with rsp_sc_ok = 0 and leaves memory unchanged.
- R4: A store-conditional to an address outside the reserved line responds with rsp_sc_ok = 0 and leaves memory unchanged.
- R5: Every store-conditional, whether it succeeds or fails, disarms the reservation.
- R6: An invalidation strobe whose address lies anywhere in the reserved line disarms the reservation; one to another line has no effect on it.
- R7: An eviction strobe whose address lies anywhere in the reserved line disarms the reservation; one to another line has no effect on it.
- R8: A context-switch pulse disarms the reservation.
- R9: An interrupt pulse disarms the reservation only while irq_kill_en is 1; with irq_kill_en at 0 it has no effect.
- R10: A new load-linked replaces any existing reservation with the new line.
- R11: The response to a request accepted in cycle n is presented with rsp_valid = 1 in cycle n+1 and in no other cycle; rsp_sc_ok is 0 except on store-conditional responses, and rsp_rdata is 0 on write (op code 1) and store-conditional responses.
- R12: A kill event in the same cycle as a store-conditional makes it fail; a load-linked in the same cycle as a kill event still leaves an armed reservation on its own line.
- R13: A plain read (op code 0) returns the stored word, and a plain write (op code 1) updates memory without touching the reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, always accepted |
| req_op | input | 2 | 0 read, 1 write, 2 load-linked, 3 store-conditional |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | DATA_W | Read data for read and load-linked |
| rsp_sc_ok | output | 1 | Store-conditional outcome |
| snoop_inv | input | 1 | Invalidation strobe |
| snoop_addr | input | ADDR_W | Invalidated word address |
| evict | input | 1 | Eviction strobe |
| evict_addr | input | ADDR_W | Evicted word address |
| ctx_switch | input | 1 | Context-switch pulse |
| irq | input | 1 | Interrupt pulse |
| irq_kill_en | input | 1 | Lets an interrupt kill the reservation |

## Verification
The checker watches, on every cycle, the one-cycle response timing, the absence of a success flag outside store-conditional responses, that a load-linked always leaves the reservation armed, that any store-conditional, context switch or enabled interrupt leaves it disarmed, and that it only ever arms after a load-linked. Whether a success actually wrote the right word, whether a failed attempt left memory intact, the line-granular matching of invalidation and eviction addresses, and the same-cycle ordering between kills and requests can only be shown by the bench's scenarios, which read memory back through the normal request port and compare against a reference model.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_READ      = 2'd0,
        OP_WRITE     = 2'd1,
        OP_LOADLINK  = 2'd2,
        OP_STORECOND = 2'd3
    } mem_op_e;

    // Which event sources are asserting a kill this cycle
    typedef struct packed {
        logic snoop_hit;
        logic evict_hit;
        logic ctx;
        logic irq;
    } kill_src_t;

    // Decoded form of an accepted request
    typedef struct packed {
        logic fire;
        logic is_read;
        logic is_write;
        logic is_ll;
        logic is_sc;
    } req_dec_t;

    function automatic req_dec_t decode_req(input logic valid, input logic [1:0] op);
        req_dec_t d;
        mem_op_e  o;
        o          = mem_op_e'(op);
        d.fire     = valid;
        d.is_read  = valid && (o == OP_READ);
        d.is_write = valid && (o == OP_WRITE);
        d.is_ll    = valid && (o == OP_LOADLINK);
        d.is_sc    = valid && (o == OP_STORECOND);
        return d;
    endfunction

    function automatic logic any_kill(input kill_src_t k);
        return k.snoop_hit | k.evict_hit | k.ctx | k.irq;
    endfunction

endpackage

// File: rtl/llsc_word_store.sv
module llsc_word_store
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
        end else if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    assign rd_data = words[rd_addr];

endmodule

// File: rtl/llsc_resv_tracker.sv
module llsc_resv_tracker
    import llsc_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int LINE_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ll_fire,
    input  logic              sc_fire,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              snoop_inv,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              evict,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic              ctx_switch,
    input  logic              irq,
    input  logic              irq_kill_en,
    output logic              sc_grant,
    output logic              resv_valid,
    output kill_src_t         kill_src
);
    localparam int OFF_W  = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 0;
    localparam int LINE_W = ADDR_W - OFF_W;

    logic [LINE_W-1:0] resv_line;
    logic [LINE_W-1:0] req_line;
    logic [LINE_W-1:0] snoop_line;
    logic [LINE_W-1:0] evict_line;

    // Line number extraction: whole address when a line is one word
    generate
        if (OFF_W == 0) begin : g_word_lines
            assign req_line   = req_addr;
            assign snoop_line = snoop_addr;
            assign evict_line = evict_addr;
        end else begin : g_multi_word_lines
            assign req_line   = req_addr[ADDR_W-1:OFF_W];
            assign snoop_line = snoop_addr[ADDR_W-1:OFF_W];
            assign evict_line = evict_addr[ADDR_W-1:OFF_W];
        end
    endgenerate

    logic kill_now;

    always_comb begin
        kill_src.snoop_hit = snoop_inv && (snoop_line == resv_line);
        kill_src.evict_hit = evict && (evict_line == resv_line);
        kill_src.ctx       = ctx_switch;
        kill_src.irq       = irq && irq_kill_en;
        kill_now           = any_kill(kill_src);
    end

    // A kill arriving with the conditional store beats it
    assign sc_grant = sc_fire && resv_valid && (req_line == resv_line) && !kill_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            resv_valid <= 1'b0;
            resv_line  <= '0;
        end else if (ll_fire) begin
            resv_valid <= 1'b1;
            resv_line  <= req_line;
        end else if (sc_fire || kill_now) begin
            resv_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/llsc_resp_stage.sv
module llsc_resp_stage
    import llsc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  req_dec_t          dec,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              sc_grant,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_sc_ok
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_sc_ok <= 1'b0;
        end else begin
            rsp_valid <= dec.fire;
            rsp_rdata <= (dec.is_read || dec.is_ll) ? rd_data : '0;
            rsp_sc_ok <= dec.is_sc && sc_grant;
        end
    end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_sc_ok,
    input  logic              snoop_inv,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              evict,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic              ctx_switch,
    input  logic              irq,
    input  logic              irq_kill_en
);
    req_dec_t          dec;
    logic              sc_grant;
    logic              resv_valid;
    kill_src_t         kill_src;
    logic              mem_wr_en;
    logic [DATA_W-1:0] mem_rd_data;

    assign dec       = decode_req(req_valid, req_op);
    assign mem_wr_en = dec.is_write || sc_grant;

    llsc_resv_tracker #(
        .ADDR_W     (ADDR_W),
        .LINE_WORDS (LINE_WORDS)
    ) u_tracker (
        .clk         (clk),
        .rst         (rst),
        .ll_fire     (dec.is_ll),
        .sc_fire     (dec.is_sc),
        .req_addr    (req_addr),
        .snoop_inv   (snoop_inv),
        .snoop_addr  (snoop_addr),
        .evict       (evict),
        .evict_addr  (evict_addr),
        .ctx_switch  (ctx_switch),
        .irq         (irq),
        .irq_kill_en (irq_kill_en),
        .sc_grant    (sc_grant),
        .resv_valid  (resv_valid),
        .kill_src    (kill_src)
    );

    llsc_word_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mem_wr_en),
        .wr_addr (req_addr),
        .wr_data (req_wdata),
        .rd_addr (req_addr),
        .rd_data (mem_rd_data)
    );

    llsc_resp_stage #(
        .DATA_W (DATA_W)
    ) u_resp (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .rd_data   (mem_rd_data),
        .sc_grant  (sc_grant),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_sc_ok (rsp_sc_ok)
    );

endmodule

// File: rtl/llsc_monitor_checker.sv
module llsc_monitor_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [1:0] req_op,
    input logic       rsp_valid,
    input logic       rsp_sc_ok,
    input logic       resv_valid,
    input logic       ctx_switch,
    input logic       irq,
    input logic       irq_kill_en
);
    logic req_ll;
    logic req_sc;
    assign req_ll = req_valid && (req_op == 2'd2);
    assign req_sc = req_valid && (req_op == 2'd3);

    assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_stray_rsp_R11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_ok_only_on_sc_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_sc) |=> !rsp_sc_ok);

    assert_sc_needs_resv_R3: assert property (@(posedge clk) disable iff (rst)
        (req_sc && !resv_valid) |=> !rsp_sc_ok);

    assert_sc_disarms_R5: assert property (@(posedge clk) disable iff (rst)
        req_sc |=> !resv_valid);

    assert_ll_arms_R1: assert property (@(posedge clk) disable iff (rst)
        req_ll |=> resv_valid);

    assert_ctx_disarms_R8: assert property (@(posedge clk) disable iff (rst)
        (ctx_switch && !req_ll) |=> !resv_valid);

    assert_irq_disarms_R9: assert property (@(posedge clk) disable iff (rst)
        (irq && irq_kill_en && !req_ll) |=> !resv_valid);

    assert_arm_only_by_ll_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(resv_valid) |-> $past(req_ll));

endmodule

bind llsc_monitor llsc_monitor_checker u_checker (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .rsp_valid   (rsp_valid),
    .rsp_sc_ok   (rsp_sc_ok),
    .resv_valid  (resv_valid),
    .ctx_switch  (ctx_switch),
    .irq         (irq),
    .irq_kill_en (irq_kill_en)
);

// File: tb/llsc_monitor_test.sv
module llsc_monitor_test;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int LW     = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    localparam logic [1:0] RD = 2'd0, WR = 2'd1, LL = 2'd2, SC = 2'd3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic              rsp_sc_ok;
    logic              snoop_inv = 1'b0;
    logic [ADDR_W-1:0] snoop_addr = '0;
    logic              evict = 1'b0;
    logic [ADDR_W-1:0] evict_addr = '0;
    logic              ctx_switch = 1'b0;
    logic              irq = 1'b0;
    logic              irq_kill_en = 1'b0;

    always #4 clk = ~clk;

    llsc_monitor #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LW)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_sc_ok(rsp_sc_ok),
        .snoop_inv(snoop_inv), .snoop_addr(snoop_addr),
        .evict(evict), .evict_addr(evict_addr),
        .ctx_switch(ctx_switch), .irq(irq), .irq_kill_en(irq_kill_en)
    );

    typedef struct {
        logic [DATA_W-1:0] data;
        bit                ok;
        string             tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    logic [DATA_W-1:0] m_mem [DEPTH];
    bit m_flag = 0;
    int m_line = 0;

    task automatic fail_line(input string tag, input string what, input longint act, input longint exp);
        errors++;
        $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    endtask

    // Drive one cycle of stimulus and push the expected response
    task automatic step(input bit v, input logic [1:0] op, input int a, input logic [DATA_W-1:0] wd,
                        input string tag,
                        input bit snp = 0, input int snp_a = 0, input bit ev = 0, input int ev_a = 0,
                        input bit cs = 0, input bit ir = 0);
        exp_t e;
        bit   kill;
        @(negedge clk);
        req_valid  = v;
        req_op     = op;
        req_addr   = ADDR_W'(a);
        req_wdata  = wd;
        snoop_inv  = snp;
        snoop_addr = ADDR_W'(snp_a);
        evict      = ev;
        evict_addr = ADDR_W'(ev_a);
        ctx_switch = cs;
        irq        = ir;
        kill = cs || (ir && irq_kill_en) || (snp && (snp_a / LW) == m_line) || (ev && (ev_a / LW) == m_line);
        if (v) begin
            e.tag  = tag;
            e.data = '0;
            e.ok   = 0;
            case (op)
                RD, LL: e.data = m_mem[a];
                WR:     m_mem[a] = wd;
                default: begin
                    e.ok = m_flag && ((a / LW) == m_line) && !kill;
                    if (e.ok) m_mem[a] = wd;
                end
            endcase
            q.push_back(e);
        end
        if (v && op == LL) begin
            m_flag = 1;
            m_line = a / LW;
        end else if ((v && op == SC) || kill) begin
            m_flag = 0;
        end
    endtask

    task automatic req(input logic [1:0] op, input int a, input logic [DATA_W-1:0] wd, input string tag);
        step(1, op, a, wd, tag);
    endtask

    task automatic idle();
        step(0, RD, 0, '0, "idle");
    endtask

    // Monitor: sample between the rising and falling edge
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            if (q.size() > 0 || rsp_valid) begin
                checks++;
                if (rsp_valid !== (q.size() > 0)) begin
                    fail_line("R11", "rsp_valid", longint'(rsp_valid), longint'(q.size() > 0));
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (rsp_rdata !== e.data) fail_line(e.tag, "rdata", longint'(rsp_rdata), longint'(e.data));
                    else if (rsp_sc_ok !== e.ok) fail_line(e.tag, "sc_ok", longint'(rsp_sc_ok), longint'(e.ok));
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) fail_line("R11", "reset rsp_valid", longint'(rsp_valid), 0);
        @(negedge clk);
        rst = 1'b0;

        // R3 reset contents and SC without reservation
        req(RD, 5, '0, "R3_reset_read");
        req(SC, 5, 32'h1111, "R3_sc_no_resv");
        req(RD, 5, '0, "R3_mem_unchanged");

        // R13 plain write and read
        req(WR, 5, 32'hA5A5_0005, "R13_write");
        req(RD, 5, '0, "R13_read");

        // R1 / R2 success within line
        req(LL, 5, '0, "R1_ll_data");
        req(SC, 6, 32'hB0B0_0006, "R2_sc_ok_same_line");
        req(RD, 6, '0, "R2_written");
        // R5 second SC fails
        req(SC, 6, 32'hDEAD_0006, "R5_sc_after_sc");
        req(RD, 6, '0, "R5_mem_unchanged");

        // R4 outside line
        req(LL, 8, '0, "R4_ll");
        req(SC, 12, 32'hCCCC_000C, "R4_sc_other_line");
        req(RD, 12, '0, "R4_mem_unchanged");

        // R6 snoop other line / same line
        req(LL, 8, '0, "R6_ll");
        step(0, RD, 0, '0, "R6_snoop_far", 1, 20);
        req(SC, 9, 32'h0000_6609, "R6_far_snoop_ok");
        req(LL, 8, '0, "R6_ll2");
        step(0, RD, 0, '0, "R6_snoop_near", 1, 11);
        req(SC, 9, 32'h0000_6619, "R6_near_snoop_fail");
        req(RD, 9, '0, "R6_mem_check");

        // R7 eviction
        req(LL, 16, '0, "R7_ll");
        step(0, RD, 0, '0, "R7_evict_far", 0, 0, 1, 40);
        req(SC, 17, 32'h0000_7717, "R7_far_evict_ok");
        req(LL, 16, '0, "R7_ll2");
        step(0, RD, 0, '0, "R7_evict_near", 0, 0, 1, 19);
        req(SC, 17, 32'h0000_7727, "R7_near_evict_fail");
        req(RD, 17, '0, "R7_mem_check");

        // R8 context switch
        req(LL, 24, '0, "R8_ll");
        step(0, RD, 0, '0, "R8_ctx", 0, 0, 0, 0, 1);
        req(SC, 24, 32'h0000_8824, "R8_ctx_fail");

        // R9 interrupt with and without enable
        irq_kill_en = 1'b0;
        req(LL, 28, '0, "R9_ll");
        step(0, RD, 0, '0, "R9_irq_off", 0, 0, 0, 0, 0, 1);
        req(SC, 28, 32'h0000_991C, "R9_irq_disabled_ok");
        step(0, RD, 0, '0, "R9_cfg", 0, 0, 0, 0, 0, 0);
        irq_kill_en = 1'b1;
        req(LL, 28, '0, "R9_ll2");
        step(0, RD, 0, '0, "R9_irq_on", 0, 0, 0, 0, 0, 1);
        req(SC, 28, 32'h0000_992C, "R9_irq_enabled_fail");
        req(RD, 28, '0, "R9_mem_check");

        // R10 replacement
        req(LL, 8, '0, "R10_ll_a");
        req(LL, 32, '0, "R10_ll_b");
        req(SC, 9, 32'h0000_1009, "R10_old_line_fail");
        req(LL, 8, '0, "R10_ll_c");
        req(LL, 32, '0, "R10_ll_d");
        req(SC, 33, 32'h0000_1021, "R10_new_line_ok");

        // R13 plain write leaves reservation
        req(LL, 40, '0, "R13_ll");
        req(WR, 41, 32'h0000_1341, "R13_write_mid");
        req(SC, 42, 32'h0000_1342, "R13_sc_still_ok");

        // R12 same-cycle ordering
        req(LL, 44, '0, "R12_ll");
        step(1, SC, 45, 32'h0000_122D, "R12_sc_with_ctx_fail", 0, 0, 0, 0, 1);
        req(RD, 45, '0, "R12_mem_check");
        step(1, LL, 48, '0, "R12_ll_with_snoop", 1, 49);
        req(SC, 50, 32'h0000_1232, "R12_ll_wins_ok");

        // Back-to-back pseudo-random mix (R1 R2 R4 R5 R11)
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int k = 0; k < 60; k++) begin
                int a;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                a = int'(lfsr[5:0]) & 6'h0F;
                step(1, lfsr[9:8], a, {16'h5A00, lfsr}, "R11_mix",
                     lfsr[11] && lfsr[3], int'(lfsr[15:10]), 0, 0, 0, lfsr[7] && lfsr[2]);
            end
        end

        idle();
        idle();
        idle();
        done = 1;
        checks++;
        if (q.size() != 0) fail_line("R11", "pending responses", longint'(q.size()), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule